// File: doc/BRIEF.md
# Packed RGB Average Register File

This block is a small dedicated register file for packed pixels. Each entry is 24 bits wide and holds three 8-bit colour lanes. Two read ports, addressed by `s_idx` and `t_idx`, feed a lane-wise averaging unit. For every byte lane, the unit forms a 9-bit sum and keeps its top eight bits, which gives a truncating mean. The unit never carries between lanes. The packed result goes back through the single write port to the entry named by `r_idx`.

Data moves between the file and memory as 32-bit words. A load takes the low 24 bits of `ld_word` and drops the top byte. Both read ports present their entry zero-extended to a 32-bit word, and that word serves as the store path.

Reads are registered. Each port captures its indexed entry at a clock edge, and a write to the same index at that edge is forwarded. An average issued at edge k captures its operands at edge k. It retires, and so writes its destination, at edge k+1.

Top module: `pixavg_regfile`

## Requirements
- R1: The file has 16 entries of 24 bits. Reset clears every entry and both read registers, so both read ports show 0 once reset is released.
- R2: At each clock edge, `rd_s_word` and `rd_t_word` capture the entries indexed by `s_idx` and `t_idx`. The captured values appear after that edge and are held until the next edge.
- R3: When `avg_en` is high at an edge, operands are read from `s_idx` and `t_idx`. At the following edge, the entry that `r_idx` named at the issue edge receives the result. For each lane [23:16], [15:8] and [7:0], the result is bits [8:1] of the 9-bit sum of the two source lanes, and no carry passes between lanes.
- R4: The average truncates and never rounds. For example, lanes 0x01 and 0x02 give 0x01, and 0xFF and 0x01 give 0x80.
- R5: When `ld_en` is high at an edge, `ld_word[23:0]` is written to the entry `ld_idx`. Bits [31:24] of `ld_word` are ignored.
- R6: Bits [31:24] of both read words are always zero. Bits [23:0] carry the entry.
- R7: A read port whose index equals the index written at the same edge captures the new data (write-first). This holds both for a load and for a retiring average.
- R8: The file has one write port. At an edge where an average retires, a load presented at that edge is discarded and leaves its target entry unchanged.
- R9: Averaging an entry with an equal value returns that value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_idx | input | 4 | First read port index, also the first average operand |
| t_idx | input | 4 | Second read port index, also the second average operand |
| r_idx | input | 4 | Destination index for an average issued this cycle |
| avg_en | input | 1 | Issue an average this cycle |
| ld_en | input | 1 | Load a memory word this cycle |
| ld_idx | input | 4 | Load target index |
| ld_word | input | 32 | Loaded memory word, low 24 bits used |
| rd_s_word | output | 32 | Registered read of `s_idx`, zero-extended |
| rd_t_word | output | 32 | Registered read of `t_idx`, zero-extended |

## Verification
The bench builds the block at its default parameters: three 8-bit lanes, sixteen entries, 32-bit memory words and write-first forwarding. With only sixteen indices, directed sequences reach a chained average whose operand is being written at the same edge, a destination that is also a source, and a load that collides with a retiring average. A random phase then makes same-index read/write coincidences frequent. Lane values 0xFF with 0x01, and 0x01 with 0x02, pin down the carry isolation between lanes and the truncation.

// File: rtl/pixavg_pkg.sv
package pixavg_pkg;

   localparam int PIXAVG_LANES_DEF  = 3;
   localparam int PIXAVG_LANE_W_DEF = 8;
   localparam int PIXAVG_DEPTH_DEF  = 16;
   localparam int PIXAVG_MEM_W_DEF  = 32;

   // source that owns the single write port in a cycle
   typedef enum logic [1:0] {
      WSRC_IDLE   = 2'd0,
      WSRC_RETIRE = 2'd1,
      WSRC_LOAD   = 2'd2
   } wsrc_e;

endpackage

// File: rtl/pixavg_lane.sv
module pixavg_lane #(
   parameter int LANE_W = 8
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   output logic [LANE_W-1:0] y
);
   localparam int SUM_W = LANE_W + 1;

   logic [SUM_W-1:0] sum;

   // widen by one bit so the carry is kept, then drop the lsb
   assign sum = {1'b0, a} + {1'b0, b};
   assign y   = sum[SUM_W-1:1];

endmodule

// File: rtl/pixavg_avg_unit.sv
module pixavg_avg_unit #(
   parameter int LANES  = 3,
   parameter int LANE_W = 8
) (
   input  logic [LANES*LANE_W-1:0] op_a,
   input  logic [LANES*LANE_W-1:0] op_b,
   output logic [LANES*LANE_W-1:0] res
);
   localparam int REG_W = LANES * LANE_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("pixavg_avg_unit: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("pixavg_avg_unit: LANE_W must be at least 1");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      pixavg_lane #(.LANE_W(LANE_W)) u_lane (
         .a (op_a[k*LANE_W +: LANE_W]),
         .b (op_b[k*LANE_W +: LANE_W]),
         .y (res [k*LANE_W +: LANE_W])
      );
   end

   if (REG_W != LANES * LANE_W) begin : g_bad_pack
      $error("pixavg_avg_unit: packed width mismatch");
   end

endmodule

// File: rtl/pixavg_wr_arb.sv
module pixavg_wr_arb
   import pixavg_pkg::*;
#(
   parameter int REG_W = 24,
   parameter int IDX_W = 4
) (
   input  logic             retire,
   input  logic [IDX_W-1:0] retire_idx,
   input  logic [REG_W-1:0] retire_data,
   input  logic             load,
   input  logic [IDX_W-1:0] load_idx,
   input  logic [REG_W-1:0] load_data,
   output logic             wen,
   output logic [IDX_W-1:0] widx,
   output logic [REG_W-1:0] wdata
);
   wsrc_e src;

   // a retiring average owns the port; a coinciding load is dropped
   always_comb begin
      if (retire)    src = WSRC_RETIRE;
      else if (load) src = WSRC_LOAD;
      else           src = WSRC_IDLE;
   end

   always_comb begin
      wen   = 1'b0;
      widx  = '0;
      wdata = '0;
      case (src)
         WSRC_RETIRE: begin
            wen   = 1'b1;
            widx  = retire_idx;
            wdata = retire_data;
         end
         WSRC_LOAD: begin
            wen   = 1'b1;
            widx  = load_idx;
            wdata = load_data;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pixavg_store.sv
module pixavg_store #(
   parameter int DEPTH       = 16,
   parameter int REG_W       = 24,
   parameter int NRD         = 2,
   parameter bit WRITE_FIRST = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wen,
   input  logic [$clog2(DEPTH)-1:0]          widx,
   input  logic [REG_W-1:0]                  wdata,
   input  logic [NRD-1:0][$clog2(DEPTH)-1:0] rd_idx,
   output logic [NRD-1:0][REG_W-1:0]         rd_q
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pixavg_store: DEPTH must be at least 2");
   end
   if (NRD < 1) begin : g_bad_nrd
      $error("pixavg_store: NRD must be at least 1");
   end

   logic [REG_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wen) begin
         mem[widx] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_port
      logic [REG_W-1:0] q;
      logic [IDX_W-1:0] ix;
      assign ix = rd_idx[p];

      if (WRITE_FIRST) begin : g_wf
         always_ff @(posedge clk) begin
            if (!rst_n)                  q <= '0;
            else if (wen && (widx == ix)) q <= wdata;
            else                         q <= mem[ix];
         end
      end else begin : g_rf
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= mem[ix];
         end
      end

      assign rd_q[p] = q;
   end

endmodule

// File: rtl/pixavg_regfile.sv
module pixavg_regfile
   import pixavg_pkg::*;
#(
   parameter int LANES       = PIXAVG_LANES_DEF,
   parameter int LANE_W      = PIXAVG_LANE_W_DEF,
   parameter int DEPTH       = PIXAVG_DEPTH_DEF,
   parameter int MEM_W       = PIXAVG_MEM_W_DEF,
   parameter bit WRITE_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [$clog2(DEPTH)-1:0] s_idx,
   input  logic [$clog2(DEPTH)-1:0] t_idx,
   input  logic [$clog2(DEPTH)-1:0] r_idx,
   input  logic                     avg_en,
   input  logic                     ld_en,
   input  logic [$clog2(DEPTH)-1:0] ld_idx,
   input  logic [MEM_W-1:0]         ld_word,
   output logic [MEM_W-1:0]         rd_s_word,
   output logic [MEM_W-1:0]         rd_t_word
);
   localparam int REG_W = LANES * LANE_W;
   localparam int IDX_W = $clog2(DEPTH);
   localparam int NRD   = 2;

   if (MEM_W < REG_W) begin : g_bad_mem_w
      $error("pixavg_regfile: MEM_W must hold a whole entry");
   end

   logic                        wb_pend;
   logic [IDX_W-1:0]            wb_dst;
   logic [REG_W-1:0]            op_a;
   logic [REG_W-1:0]            op_b;
   logic [REG_W-1:0]            avg_res;
   logic                        wen;
   logic [IDX_W-1:0]            widx;
   logic [REG_W-1:0]            wdata;
   logic [NRD-1:0][IDX_W-1:0]   rd_idx;
   logic [NRD-1:0][REG_W-1:0]   rd_q;
   logic                        unused_ld_hi;

   // the top byte of a loaded word carries nothing
   assign unused_ld_hi = ^ld_word;

   // issue stage: operands are captured by the read ports, retire next edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_pend <= 1'b0;
         wb_dst  <= '0;
      end else begin
         wb_pend <= avg_en;
         wb_dst  <= r_idx;
      end
   end

   assign rd_idx = {t_idx, s_idx};
   assign op_a   = rd_q[0];
   assign op_b   = rd_q[1];

   pixavg_store #(
      .DEPTH       (DEPTH),
      .REG_W       (REG_W),
      .NRD         (NRD),
      .WRITE_FIRST (WRITE_FIRST)
   ) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .wen    (wen),
      .widx   (widx),
      .wdata  (wdata),
      .rd_idx (rd_idx),
      .rd_q   (rd_q)
   );

   pixavg_avg_unit #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_avg (
      .op_a (op_a),
      .op_b (op_b),
      .res  (avg_res)
   );

   pixavg_wr_arb #(
      .REG_W (REG_W),
      .IDX_W (IDX_W)
   ) u_arb (
      .retire      (wb_pend),
      .retire_idx  (wb_dst),
      .retire_data (avg_res),
      .load        (ld_en),
      .load_idx    (ld_idx),
      .load_data   (ld_word[REG_W-1:0]),
      .wen         (wen),
      .widx        (widx),
      .wdata       (wdata)
   );

   assign rd_s_word = MEM_W'(op_a);
   assign rd_t_word = MEM_W'(op_b);

endmodule

// File: rtl/pixavg_chk.sv
module pixavg_chk #(
   parameter int LANES       = 3,
   parameter int LANE_W      = 8,
   parameter int DEPTH       = 16,
   parameter int MEM_W       = 32,
   parameter bit WRITE_FIRST = 1'b1
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [$clog2(DEPTH)-1:0]        s_idx,
   input logic                            ld_en,
   input logic [$clog2(DEPTH)-1:0]        ld_idx,
   input logic [LANES*LANE_W-1:0]         ld_low,
   input logic [MEM_W-1:0]                rd_s_word,
   input logic                            wb_pend,
   input logic [LANES*LANE_W-1:0]         op_a,
   input logic [LANES*LANE_W-1:0]         op_b,
   input logic [LANES*LANE_W-1:0]         avg_res
);
   localparam int REG_W = LANES * LANE_W;

   function automatic bit lanes_bounded(input logic [REG_W-1:0] a,
                                        input logic [REG_W-1:0] b,
                                        input logic [REG_W-1:0] y);
      bit ok;
      ok = 1'b1;
      for (int k = 0; k < LANES; k++) begin
         logic [LANE_W-1:0] la, lb, ly;
         la = a[k*LANE_W +: LANE_W];
         lb = b[k*LANE_W +: LANE_W];
         ly = y[k*LANE_W +: LANE_W];
         if (la <= lb) begin
            if (ly < la || ly > lb) ok = 1'b0;
         end else begin
            if (ly < lb || ly > la) ok = 1'b0;
         end
      end
      return ok;
   endfunction

   AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (rd_s_word == '0)); // R1

   AST_AVG_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      wb_pend |-> lanes_bounded(op_a, op_b, avg_res)); // R3

   AST_SELF_AVG: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_pend && (op_a == op_b)) |-> (avg_res == op_a)); // R9

   if (WRITE_FIRST) begin : g_wf_chk
      AST_LOAD_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ld_en && !wb_pend && (ld_idx == s_idx)) |->
            (rd_s_word[REG_W-1:0] == $past(ld_low))); // R7
   end

endmodule

bind pixavg_regfile pixavg_chk #(
   .LANES       (LANES),
   .LANE_W      (LANE_W),
   .DEPTH       (DEPTH),
   .MEM_W       (MEM_W),
   .WRITE_FIRST (WRITE_FIRST)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_idx     (s_idx),
   .ld_en     (ld_en),
   .ld_idx    (ld_idx),
   .ld_low    (ld_word[REG_W-1:0]),
   .rd_s_word (rd_s_word),
   .wb_pend   (wb_pend),
   .op_a      (op_a),
   .op_b      (op_b),
   .avg_res   (avg_res)
);

// File: tb/sim_pixavg_regfile.sv
`timescale 1ns/100ps
module sim_pixavg_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  s_idx = '0, t_idx = '0, r_idx = '0, ld_idx = '0;
   logic        avg_en = 1'b0, ld_en = 1'b0;
   logic [31:0] ld_word = '0;
   logic [31:0] rd_s_word, rd_t_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pixavg_regfile u0 (
      .clk(clk), .rst_n(rst_n), .s_idx(s_idx), .t_idx(t_idx), .r_idx(r_idx),
      .avg_en(avg_en), .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
      .rd_s_word(rd_s_word), .rd_t_word(rd_t_word)
   );

   typedef struct {
      string       tag;
      logic [31:0] es;
      logic [31:0] et;
   } exp_t;
   exp_t sbq[$];

   // reference state built from the requirements
   logic [23:0] m_mem [16];
   logic        m_pend = 1'b0;
   logic [3:0]  m_dst  = '0;
   logic [23:0] m_opa  = '0, m_opb = '0;

   function automatic logic [23:0] ref_avg(input logic [23:0] a, input logic [23:0] b);
      logic [23:0] o;
      for (int k = 0; k < 3; k++) begin
         logic [8:0] sm;
         sm = {1'b0, a[8*k +: 8]} + {1'b0, b[8*k +: 8]};
         o[8*k +: 8] = sm[8:1];
      end
      return o;
   endfunction

   // driver: applies one cycle of stimulus and predicts the reads after the edge
   task automatic step(input string tag, input logic [3:0] s, input logic [3:0] t,
                       input logic av, input logic [3:0] r,
                       input logic ld, input logic [3:0] li, input logic [31:0] lw);
      logic        wen;
      logic [3:0]  wi;
      logic [23:0] wd, na, nb;
      exp_t        e;
      s_idx = s; t_idx = t; avg_en = av; r_idx = r;
      ld_en = ld; ld_idx = li; ld_word = lw;
      wen = m_pend | ld;
      wi  = m_pend ? m_dst : li;
      wd  = m_pend ? ref_avg(m_opa, m_opb) : lw[23:0];
      na  = (wen && wi == s) ? wd : m_mem[s];
      nb  = (wen && wi == t) ? wd : m_mem[t];
      if (wen) m_mem[wi] = wd;
      m_opa = na; m_opb = nb; m_pend = av; m_dst = r;
      e.tag = tag; e.es = {8'h00, na}; e.et = {8'h00, nb};
      sbq.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle_read(input string tag, input logic [3:0] s, input logic [3:0] t);
      step(tag, s, t, 1'b0, 4'd0, 1'b0, 4'd0, 32'h0);
   endtask

   task automatic load(input string tag, input logic [3:0] li, input logic [31:0] lw,
                       input logic [3:0] s, input logic [3:0] t);
      step(tag, s, t, 1'b0, 4'd0, 1'b1, li, lw);
   endtask

   // monitor: compares each prediction just after the edge that produced it
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (sbq.size() > 0 && !done) begin
         e = sbq.pop_front();
         checks++;
         if (rd_s_word !== e.es) begin
            errors++;
            $display("FAIL %s rd_s_word actual %h expected %h", e.tag, rd_s_word, e.es);
         end
         checks++;
         if (rd_t_word !== e.et) begin
            errors++;
            $display("FAIL %s rd_t_word actual %h expected %h", e.tag, rd_t_word, e.et);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: every entry reads zero after reset
      for (int i = 0; i < 16; i++) idle_read("R1 reset zero", i[3:0], 4'(15 - i));

      // R5 R7: loads with junk top byte, same-index read forwards the new data
      for (int i = 0; i < 16; i++)
         load("R5 R7 load forward", i[3:0], {8'hA5 ^ 8'(i), 8'(17 * i), 8'(3 + 29 * i), 8'(250 - 7 * i)},
              i[3:0], 4'(i + 15));

      // R2 R6: plain read-back on both ports, top byte zero
      for (int i = 0; i < 16; i++) idle_read("R2 R6 read back", i[3:0], 4'(i + 8));

      // set up lane patterns
      load("R5 setup", 4'd0, 32'hFFFF_FFFF, 4'd0, 4'd1);
      load("R5 setup", 4'd1, 32'h7701_0101, 4'd0, 4'd1);
      load("R5 setup", 4'd2, 32'h0001_0203, 4'd1, 4'd2);
      load("R5 setup", 4'd3, 32'h1102_0304, 4'd2, 4'd3);

      // R3 R4: 0xFF with 0x01 gives 0x80 per lane, no carry across lanes
      step("R3 carry isolation", 4'd0, 4'd1, 1'b1, 4'd4, 1'b0, 4'd0, 32'h0);
      idle_read("R3 R7 retire forward", 4'd4, 4'd0);
      idle_read("R3 result", 4'd4, 4'd4);

      // R4: 1+2 truncates to 1
      step("R4 truncation", 4'd2, 4'd3, 1'b1, 4'd10, 1'b0, 4'd0, 32'h0);
      idle_read("R4 pipe", 4'd10, 4'd2);
      idle_read("R4 result", 4'd10, 4'd3);

      // R9: averaging with itself
      step("R9 self average", 4'd3, 4'd3, 1'b1, 4'd5, 1'b0, 4'd0, 32'h0);
      idle_read("R9 pipe", 4'd5, 4'd3);
      idle_read("R9 result", 4'd5, 4'd3);

      // R7: chained averages, second reads the entry the first retires into
      step("R7 chain issue", 4'd0, 4'd2, 1'b1, 4'd6, 1'b0, 4'd0, 32'h0);
      step("R7 chain forward", 4'd6, 4'd1, 1'b1, 4'd7, 1'b0, 4'd0, 32'h0);
      idle_read("R7 chain result", 4'd7, 4'd6);

      // R3: destination equals a source
      step("R3 dst is src", 4'd3, 4'd4, 1'b1, 4'd3, 1'b0, 4'd0, 32'h0);
      idle_read("R3 dst is src pipe", 4'd3, 4'd4);
      idle_read("R3 dst is src result", 4'd3, 4'd4);

      // R8: load coinciding with a retiring average is dropped
      step("R8 issue", 4'd1, 4'd2, 1'b1, 4'd8, 1'b0, 4'd0, 32'h0);
      step("R8 colliding load", 4'd9, 4'd8, 1'b0, 4'd0, 1'b1, 4'd9, 32'h00AB_CDEF);
      idle_read("R8 load dropped", 4'd9, 4'd8);

      // R3 R7 R8: random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] rv;
         rv = $urandom;
         step("R3 R7 R8 random mix", rv[3:0], rv[7:4], rv[8], rv[12:9],
              rv[13], rv[17:14], $urandom);
      end
      idle_read("R2 drain", 4'd0, 4'd1);
      idle_read("R2 drain", 4'd2, 4'd3);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule